// File: doc/BRIEF.md
# Busy-Driven Frequency Step Governor

This block watches an engine's busy/idle indication, sampled once per timebase tick (nominally one microsecond), and decides when the engine clock should move one frequency bin up or one bin down. It keeps the current bin, steps it by exactly one per decision, and holds it inside a programmable window bounded by a floor bin and a ceiling bin. Each decision is announced by a single-cycle pulse on a step output.

Two independent evaluation paths run side by side. The up path judges activity by an unbroken busy run, a busy count over an interval, or an idle count over an interval. The down path judges by an unbroken idle run or a busy count over an interval. A small encoded mode word picks the test for each path, and each path has its own interval and threshold. An idle hysteresis filter stops short idle gaps from breaking a busy run or from counting as idle for the run-based tests. After any bin change every counter starts over, so that one burst of activity cannot cause two steps. All pins are plain control and status levels or pulses. There is no data stream and no handshake.

Top module: `busy_step_gov`

## Requirements
- R1: While reset is asserted, `cur_bin_o` equals parameter `INIT_BIN`, and `step_up_o` and `step_down_o` are low.
- R2: The up test is selected by `mode_i[5:3]`: 1 is idle-minimum, 2 is busy average, 4 is busy run. The down test is selected by `mode_i[2:0]`: 1 is idle run, 2 is busy average. Any other value disables that path, and it then never steps.
- R3: In busy-run up mode, a step up is requested on the tick that makes the count of busy ticks since the last counted idle tick reach `up_threshold_i`. A counted idle tick clears the run. `up_interval_i` has no effect in this mode.
- R4: A raw idle tick counts as idle for the run tests only once it is at least the `idle_hyst_i`-th consecutive idle tick. Idle ticks before that neither clear the busy run nor advance the idle run. A busy tick restarts the idle streak.
- R5: In busy-average down mode, a window closes on its `down_interval_i`-th tick. If the busy ticks in that window number fewer than `down_threshold_i`, a step down is requested on that tick.
- R6: In busy-average up mode, an up window closes on its `up_interval_i`-th tick. A step up is requested if that window held at least `up_threshold_i` busy ticks.
- R7: In idle-minimum up mode, a step up is requested when a closing up window held fewer than `up_threshold_i` idle ticks.
- R8: In idle-run down mode, a step down is requested on the tick that makes the run of counted idle ticks reach `down_threshold_i`. Any busy tick clears that run.
- R9: Every step pulse lasts one clock cycle. It appears in the cycle after the clock edge that sampled the deciding tick, together with the new bin, which differs from the old one by exactly one. The bin never changes without a pulse.
- R10: `bin_limits_i[15:8]` is the ceiling bin and `bin_limits_i[7:0]` is the floor bin. An up request at or above the ceiling, or a down request at or below the floor, is dropped with no pulse and no bin change.
- R11: A bin change restarts both interval windows and both run counters on the same edge.
- R12: If up and down requests fall due on the same tick, only the up request is acted on, and the two pulses are never high together.
- R13: Cycles with `tick_i` low change no counter and produce no step, whatever `busy_i` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase tick, one cycle wide |
| busy_i | input | 1 | Engine busy level, sampled on tick cycles |
| mode_i | input | 6 | [5:3] up test, [2:0] down test |
| bin_limits_i | input | 16 | [15:8] ceiling bin, [7:0] floor bin |
| up_interval_i | input | CNT_W | Up window length in ticks |
| up_threshold_i | input | CNT_W | Up run length or up window count limit |
| down_interval_i | input | CNT_W | Down window length in ticks |
| down_threshold_i | input | CNT_W | Down run length or down window busy limit |
| idle_hyst_i | input | CNT_W | Consecutive idle ticks before idle counts for the run tests |
| step_up_o | output | 1 | One-cycle pulse on a step up |
| step_down_o | output | 1 | One-cycle pulse on a step down |
| cur_bin_o | output | 8 | Current frequency bin |

## Verification
The bench builds the block with `CNT_W` = 10 and `INIT_BIN` = 4. Starting mid-range means both directions and both limits can be reached from reset in a few ticks, without first climbing. Intervals and thresholds are programmed in single digits or tens, so windows closing, runs breaking, hysteresis holding a run, limit suppression and simultaneous up and down decisions all happen within a few dozen ticks, each at a tick number the scoreboard predicts exactly.

// File: rtl/gov_pkg.sv
package gov_pkg;
  localparam int BIN_W       = 8;
  localparam int MODE_W      = 3;
  localparam int UPM_LSB     = 3;
  localparam int DNM_LSB     = 0;
  localparam int LIM_MAX_LSB = 8;
  localparam int LIM_MIN_LSB = 0;

  localparam logic [MODE_W-1:0] UPM_IDLE_MIN = 3'd1;
  localparam logic [MODE_W-1:0] UPM_BUSY_AVG = 3'd2;
  localparam logic [MODE_W-1:0] UPM_BUSY_RUN = 3'd4;
  localparam logic [MODE_W-1:0] DNM_IDLE_RUN = 3'd1;
  localparam logic [MODE_W-1:0] DNM_BUSY_AVG = 3'd2;
endpackage

// File: rtl/gov_idle_filter.sv
module gov_idle_filter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             busy_i,
  input  logic [CNT_W-1:0] hyst_i,
  output logic             eff_idle_o
);
  logic [CNT_W-1:0] streak_q;
  logic [CNT_W:0]   streak_inc;

  assign streak_inc = {1'b0, streak_q} + 1'b1;
  assign eff_idle_o = tick_i && !busy_i && (streak_inc >= {1'b0, hyst_i});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      streak_q <= '0;
    end else if (tick_i) begin
      if (busy_i)           streak_q <= '0;
      else if (!(&streak_q)) streak_q <= streak_q + 1'b1;
    end
  end

  // R4: a busy tick restarts the idle streak
  p_busy_clears_streak_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && busy_i) |=> (streak_q == '0));
endmodule

// File: rtl/gov_run_counter.sv
module gov_run_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             inc_i,
  input  logic             clr_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             due_o
);
  logic [CNT_W-1:0] run_q, run_nxt;

  always_comb begin
    run_nxt = run_q;
    if (inc_i && !(&run_q)) run_nxt = run_q + 1'b1;
    else if (clr_i)         run_nxt = '0;
  end

  assign due_o = inc_i && (run_nxt >= thr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_q <= '0;
    else if (restart_i) run_q <= '0;
    else                run_q <= run_nxt;
  end

  // R13: without a tick the run length holds
  p_run_holds_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(run_q));
endmodule

// File: rtl/gov_window.sv
module gov_window #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             busy_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] interval_i,
  output logic             end_o,
  output logic [CNT_W-1:0] busy_tot_o
);
  logic [CNT_W-1:0] pos_q, bsy_q;
  logic [CNT_W:0]   len;

  assign len        = {1'b0, pos_q} + 1'b1;
  assign end_o      = tick_i && (len >= {1'b0, interval_i});
  assign busy_tot_o = bsy_q + CNT_W'(tick_i && busy_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      bsy_q <= '0;
    end else if (restart_i || end_o) begin
      pos_q <= '0;
      bsy_q <= '0;
    end else if (tick_i) begin
      pos_q <= pos_q + 1'b1;
      bsy_q <= busy_tot_o;
    end
  end

  // R5: busy ticks can never outnumber the ticks seen in the window
  p_busy_within_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bsy_q <= pos_q);
endmodule

// File: rtl/gov_bin_ctrl.sv
module gov_bin_ctrl #(
  parameter int BIN_W    = 8,
  parameter int INIT_BIN = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             want_up_i,
  input  logic             want_dn_i,
  input  logic [BIN_W-1:0] ceil_i,
  input  logic [BIN_W-1:0] floor_i,
  output logic             take_o,
  output logic             step_up_o,
  output logic             step_dn_o,
  output logic [BIN_W-1:0] bin_o
);
  logic [BIN_W-1:0] bin_q;
  logic             take_up, take_dn;

  assign take_up = want_up_i && (bin_q < ceil_i);
  assign take_dn = !want_up_i && want_dn_i && (bin_q > floor_i);
  assign take_o  = take_up || take_dn;
  assign bin_o   = bin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q     <= BIN_W'(INIT_BIN);
      step_up_o <= 1'b0;
      step_dn_o <= 1'b0;
    end else begin
      step_up_o <= take_up;
      step_dn_o <= take_dn;
      if (take_up)      bin_q <= bin_q + 1'b1;
      else if (take_dn) bin_q <= bin_q - 1'b1;
    end
  end

  // R9: a step up raises the bin by one
  p_up_by_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    step_up_o |-> (bin_q == BIN_W'($past(bin_q) + 1'b1)));
  // R9: a step down lowers the bin by one
  p_down_by_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    step_dn_o |-> (bin_q == BIN_W'($past(bin_q) - 1'b1)));
  // R9: no pulse, no bin change
  p_quiet_bin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_up_o && !step_dn_o) |-> $stable(bin_q));
  // R10: a step up never lands above the ceiling
  p_under_ceiling_r10: assert property (@(posedge clk) disable iff (!rst_n)
    step_up_o |-> (bin_q <= $past(ceil_i)));
  // R10: a step down never lands below the floor
  p_over_floor_r10: assert property (@(posedge clk) disable iff (!rst_n)
    step_dn_o |-> (bin_q >= $past(floor_i)));
  // R12: the two pulses are exclusive
  p_pulse_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up_o && step_dn_o));
endmodule

// File: rtl/busy_step_gov.sv
module busy_step_gov
  import gov_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int INIT_BIN = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             busy_i,
  input  logic [5:0]       mode_i,
  input  logic [15:0]      bin_limits_i,
  input  logic [CNT_W-1:0] up_interval_i,
  input  logic [CNT_W-1:0] up_threshold_i,
  input  logic [CNT_W-1:0] down_interval_i,
  input  logic [CNT_W-1:0] down_threshold_i,
  input  logic [CNT_W-1:0] idle_hyst_i,
  output logic             step_up_o,
  output logic             step_down_o,
  output logic [BIN_W-1:0] cur_bin_o
);
  logic [MODE_W-1:0] up_mode, dn_mode;
  logic              busy_tick, eff_idle, restart;
  logic              up_run_due, dn_run_due, up_end, dn_end;
  logic [CNT_W-1:0]  up_busy, dn_busy, up_len, up_idle;
  logic              want_up, want_dn;

  assign up_mode   = mode_i[UPM_LSB +: MODE_W];
  assign dn_mode   = mode_i[DNM_LSB +: MODE_W];
  assign busy_tick = tick_i && busy_i;

  gov_idle_filter #(.CNT_W(CNT_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .busy_i(busy_i),
    .hyst_i(idle_hyst_i), .eff_idle_o(eff_idle));

  gov_run_counter #(.CNT_W(CNT_W)) u_busy_run (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .inc_i(busy_tick),
    .clr_i(eff_idle), .restart_i(restart), .thr_i(up_threshold_i),
    .due_o(up_run_due));

  gov_run_counter #(.CNT_W(CNT_W)) u_idle_run (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .inc_i(eff_idle),
    .clr_i(busy_tick), .restart_i(restart), .thr_i(down_threshold_i),
    .due_o(dn_run_due));

  gov_window #(.CNT_W(CNT_W)) u_up_win (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .busy_i(busy_i),
    .restart_i(restart), .interval_i(up_interval_i),
    .end_o(up_end), .busy_tot_o(up_busy));

  gov_window #(.CNT_W(CNT_W)) u_dn_win (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .busy_i(busy_i),
    .restart_i(restart), .interval_i(down_interval_i),
    .end_o(dn_end), .busy_tot_o(dn_busy));

  // a zero interval closes a window on every tick, i.e. length one
  assign up_len  = (up_interval_i == '0) ? CNT_W'(1) : up_interval_i;
  assign up_idle = up_len - up_busy;

  always_comb begin
    unique case (up_mode)
      UPM_BUSY_RUN: want_up = up_run_due;
      UPM_BUSY_AVG: want_up = up_end && (up_busy >= up_threshold_i);
      UPM_IDLE_MIN: want_up = up_end && (up_idle < up_threshold_i);
      default:      want_up = 1'b0;
    endcase
    unique case (dn_mode)
      DNM_IDLE_RUN: want_dn = dn_run_due;
      DNM_BUSY_AVG: want_dn = dn_end && (dn_busy < down_threshold_i);
      default:      want_dn = 1'b0;
    endcase
  end

  gov_bin_ctrl #(.BIN_W(BIN_W), .INIT_BIN(INIT_BIN)) u_bin (
    .clk(clk), .rst_n(rst_n), .want_up_i(want_up), .want_dn_i(want_dn),
    .ceil_i(bin_limits_i[LIM_MAX_LSB +: BIN_W]),
    .floor_i(bin_limits_i[LIM_MIN_LSB +: BIN_W]),
    .take_o(restart), .step_up_o(step_up_o), .step_dn_o(step_down_o),
    .bin_o(cur_bin_o));

  // R13: a cycle without a tick yields no step in the next cycle
  p_no_tick_no_step_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> (!step_up_o && !step_down_o));
endmodule

// File: tb/tb_busy_step_gov.sv
module tb_busy_step_gov;
  localparam int CW = 10;
  localparam int IB = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          busy = 1'b0;
  logic [5:0]    mode = '0;
  logic [15:0]   lim = '0;
  logic [CW-1:0] uint_r = '0, uthr = '0, dint = '0, dthr = '0, hyst = '0;
  logic          up, dn;
  logic [7:0]    cur_bin;

  always #10 clk = ~clk;

  busy_step_gov #(.CNT_W(CW), .INIT_BIN(IB)) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .busy_i(busy), .mode_i(mode),
    .bin_limits_i(lim), .up_interval_i(uint_r), .up_threshold_i(uthr),
    .down_interval_i(dint), .down_threshold_i(dthr), .idle_hyst_i(hyst),
    .step_up_o(up), .step_down_o(dn), .cur_bin_o(cur_bin));

  typedef struct {bit up; int t; int bin; string req;} ev_t;
  ev_t sb[$];
  ev_t e;
  int  checks = 0, fails = 0, tick_no = 0;
  bit  done = 1'b0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect_step(bit u, int t, int bin, string req);
    sb.push_back('{u, t, bin, req});
  endtask

  task automatic tk(bit b);
    @(negedge clk); tick = 1'b1; busy = b; tick_no++;
  endtask

  task automatic no_tk(bit b);
    @(negedge clk); tick = 1'b0; busy = b;
  endtask

  task automatic ticks(bit b, int n);
    for (int i = 0; i < n; i++) tk(b);
  endtask

  function automatic logic [5:0] md(int u, int d);
    return {u[2:0], d[2:0]};
  endfunction

  task automatic start(logic [5:0] m, int ceil_b, int floor_b, int ui, int ut,
                       int di, int dt, int hy);
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0; busy = 1'b0;
    mode = m; lim = {ceil_b[7:0], floor_b[7:0]};
    uint_r = CW'(ui); uthr = CW'(ut); dint = CW'(di); dthr = CW'(dt); hyst = CW'(hy);
    repeat (2) @(negedge clk);
    chk(cur_bin == 8'(IB), "R1", "bin in reset", cur_bin, IB);
    chk(!up && !dn, "R1", "pulses in reset", {up, dn}, 0);
    rst_n = 1'b1;
    tick_no = 0;
  endtask

  task automatic settle(string req, int bin);
    repeat (3) no_tk(1'b0);
    chk(sb.size() == 0, req, "steps still pending", sb.size(), 0);
    sb.delete();
    chk(cur_bin == 8'(bin), req, "final bin", cur_bin, bin);
  endtask

  // monitor: pop and compare each step as the design produces it
  initial forever begin
    @(posedge clk); #2;
    if (rst_n && (up || dn)) begin
      if (up && dn) chk(1'b0, "R12", "both pulses high", 1, 0);
      else if (sb.size() == 0) chk(1'b0, "R9", "unexpected step at tick", tick_no, -1);
      else begin
        e = sb.pop_front();
        chk(e.up == up, e.req, "direction up", up, e.up);
        chk(e.t == tick_no, e.req, "step tick", tick_no, e.t);
        chk(cur_bin == 8'(e.bin), e.req, "bin after step", cur_bin, e.bin);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R3, R9: busy runs, idle break, interval ignored
    start(md(4, 0), 15, 0, 3, 5, 8, 1, 1);
    expect_step(1, 5, 5, "R3");
    expect_step(1, 10, 6, "R9");
    expect_step(1, 19, 7, "R3");
    ticks(1, 10); ticks(1, 3); tk(0); ticks(1, 5);
    settle("R3", 7);

    // R4: short idle gaps hold the busy run
    start(md(4, 0), 15, 0, 8, 5, 8, 1, 3);
    expect_step(1, 7, 5, "R4");
    expect_step(1, 17, 6, "R4");
    ticks(1, 3); ticks(0, 2); ticks(1, 2);
    ticks(1, 2); ticks(0, 3); ticks(1, 4); tk(1);
    settle("R4", 6);

    // R5: busy-average down windows
    start(md(0, 2), 15, 0, 8, 1, 10, 7, 1);
    expect_step(0, 10, 3, "R5");
    expect_step(0, 30, 2, "R5");
    ticks(1, 6); ticks(0, 4); ticks(1, 7); ticks(0, 3); ticks(0, 10);
    settle("R5", 2);

    // R6: busy-average up windows
    start(md(2, 0), 15, 0, 8, 6, 8, 1, 1);
    expect_step(1, 8, 5, "R6");
    ticks(1, 6); ticks(0, 2); ticks(1, 5); ticks(0, 3);
    settle("R6", 5);

    // R7: idle-minimum up windows
    start(md(1, 0), 15, 0, 8, 3, 8, 1, 1);
    expect_step(1, 8, 5, "R7");
    ticks(1, 6); ticks(0, 2); ticks(1, 4); ticks(0, 4);
    settle("R7", 5);

    // R8: idle runs, busy break
    start(md(0, 1), 15, 0, 8, 1, 8, 4, 1);
    expect_step(0, 8, 3, "R8");
    expect_step(0, 12, 2, "R8");
    ticks(0, 3); tk(1); ticks(0, 4); ticks(0, 4);
    settle("R8", 2);

    // R10: ceiling suppresses further ups
    start(md(4, 0), 5, 3, 8, 2, 8, 1, 1);
    expect_step(1, 2, 5, "R10");
    ticks(1, 6);
    settle("R10", 5);
    // R10: floor suppresses further downs
    start(md(0, 1), 5, 3, 8, 1, 8, 2, 1);
    expect_step(0, 2, 3, "R10");
    ticks(0, 6);
    settle("R10", 3);

    // R12: up wins over a down due on the same tick
    start(md(4, 2), 15, 0, 8, 10, 10, 11, 1);
    expect_step(1, 10, 5, "R12");
    ticks(1, 10);
    settle("R12", 5);

    // R11: the down window restarts on the up step
    start(md(4, 2), 15, 0, 8, 3, 6, 3, 1);
    expect_step(1, 3, 5, "R11");
    expect_step(0, 9, 4, "R11");
    ticks(1, 3); ticks(0, 6);
    settle("R11", 4);

    // R13: non-tick cycles neither count busy nor break the run
    start(md(4, 0), 15, 0, 8, 3, 8, 1, 1);
    expect_step(1, 3, 5, "R13");
    tk(1); repeat (4) no_tk(1); repeat (3) no_tk(0); tk(1); tk(1);
    settle("R13", 5);

    // R2: unassigned mode values disable both paths
    start(md(3, 3), 15, 0, 2, 1, 2, 5, 1);
    ticks(1, 6); ticks(0, 6); ticks(1, 4);
    settle("R2", IB);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule